// File: doc/BRIEF.md
# Sweep Interrupt Capture and Serial Frequency Readback

This block sits beside a frequency-sweep generator. It watches an external trigger line and, when a rising edge arrives, takes a snapshot of the synthesizer's current frequency word. The word has two parts: a 12-bit integer part and a 25-bit fractional part. A 2-bit interrupt mode sets what happens next. The trigger can be ignored, or the word can be captured while the sweep carries on, or the word can be captured and the sweep generator asked to halt.

Once a word is captured, an interrupt-pending flag goes high and the word is read out on a single serial pin. The word moves forward one bit on each falling edge of a slow readback clock that the reading device supplies. The trigger line and the readback clock are asynchronous to the system clock. Both pass through a synchronizer of `SYNC_STAGES` flops, and the block acts on their edges in the system clock domain.

Top module: `sweep_irq_capture`

## Requirements
- R1: A capture is started only by a low-to-high transition of `trig_i`. A level held high, or a high-to-low transition, starts nothing.
- R2: With `irq_mode_i` equal to 2'b00 or 2'b10, trigger edges are ignored: `irq_pending_o` stays 0 and `rb_data_o` stays 0.
- R3: With `irq_mode_i` = 2'b01, a trigger rising edge captures the word and raises `irq_pending_o` within SYNC_STAGES+2 system clocks, and `sweep_halt_o` stays 0.
- R4: With `irq_mode_i` = 2'b11, a trigger rising edge captures the word and raises both `irq_pending_o` and `sweep_halt_o`.
- R5: The captured word is 37 bits. `int_word_i` (12 bits) occupies bits 36..25 and `frac_word_i` (25 bits) occupies bits 24..0. It is sent most significant bit first. Bit 36 appears on `rb_data_o` at capture, and each falling edge of `rb_clk_i` advances the output by one bit.
- R6: While a capture is pending, further trigger edges are ignored, and the word being read out is not replaced.
- R7: After the 37th falling edge of `rb_clk_i`, `irq_pending_o` clears and `rb_data_o` returns to 0.
- R8: `sweep_halt_o` stays high, including after the readback ends, until reset or until `irq_mode_i` changes value.
- R9: Reset (`rst_ni` low) clears all three outputs to 0.
- R10: Edges of `rb_clk_i` while no capture is pending have no effect: `rb_data_o` stays 0, and the next capture is still read out in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| trig_i | input | 1 | Asynchronous capture trigger |
| irq_mode_i | input | 2 | Interrupt mode: 00/10 off, 01 capture, 11 capture and halt |
| int_word_i | input | 12 | Live integer part of the frequency word |
| frac_word_i | input | 25 | Live fractional part of the frequency word |
| rb_clk_i | input | 1 | Asynchronous readback shift clock |
| sweep_halt_o | output | 1 | Request to stop the sweep |
| irq_pending_o | output | 1 | A captured word is waiting or being read out |
| rb_data_o | output | 1 | Serial readback data |

## Verification
The bench sends trigger pulses under all four mode codes, so the bench can tell ignored modes apart from capturing modes, and capture-only apart from capture-with-halt. It reads back words with different bit patterns, including mixed values, all ones and alternating bits, to expose errors in field order, bit order or bit count. Other tests separate a real rising edge from a level that is already high, a retrigger during readback from a fresh capture, and readback-clock activity while idle from activity while pending. A mode change and a reset show whether the halt request is held and then released.

// File: rtl/sweep_irq_pkg.sv
package sweep_irq_pkg;

    localparam int DEF_INT_W       = 12;
    localparam int DEF_FRAC_W      = 25;
    localparam int DEF_SYNC_STAGES = 2;

    typedef enum logic [1:0] {
        IRQ_OFF     = 2'b00,
        IRQ_RUN     = 2'b01,
        IRQ_OFF_ALT = 2'b10,
        IRQ_HALT    = 2'b11
    } irq_mode_e;

    function automatic logic mode_captures(input logic [1:0] m);
        return (m == IRQ_RUN) || (m == IRQ_HALT);
    endfunction

    function automatic logic mode_halts(input logic [1:0] m);
        return (m == IRQ_HALT);
    endfunction

endpackage

// File: rtl/irq_sync_edge.sv
module irq_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic rise_o,
    output logic fall_o
);

    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_state_t;

    sync_state_t st_d, st_q;
    logic        level;

    assign level = st_q.chain[STAGES-1];

    always_comb begin
        st_d          = st_q;
        st_d.chain    = st_q.chain << 1;
        st_d.chain[0] = async_i;
        st_d.prev     = level;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rise_o = level & ~st_q.prev;
    assign fall_o = ~level & st_q.prev;

    // R1: a detected edge is a single-cycle pulse
    assert_rise_single_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rise_o |=> !rise_o);
    assert_fall_single_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fall_o |=> !fall_o);

endmodule

// File: rtl/irq_capture_ctrl.sv
module irq_capture_ctrl
    import sweep_irq_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       trig_rise_i,
    input  logic [1:0] mode_i,
    input  logic       busy_i,
    output logic       load_o,
    output logic       halt_o
);

    typedef struct packed {
        logic       halt;
        logic [1:0] mode_seen;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;
    logic        accept;

    always_comb begin
        accept         = trig_rise_i && mode_captures(mode_i) && !busy_i;
        st_d           = st_q;
        st_d.mode_seen = mode_i;
        if (accept && mode_halts(mode_i)) begin
            st_d.halt = 1'b1;
        end else if (mode_i != st_q.mode_seen) begin
            st_d.halt = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign load_o = accept;
    assign halt_o = st_q.halt;

    // R4: halt only rises when the halting mode was selected
    assert_halt_rise_mode_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(halt_o) |-> $past(mode_i) == IRQ_HALT);
    // R8: with the mode unchanged, the halt request is held
    assert_halt_holds_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (halt_o && mode_i == $past(mode_i)) |=> halt_o);

endmodule

// File: rtl/irq_readback_shifter.sv
module irq_readback_shifter #(
    parameter int WORD_W = 37
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              load_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic              shift_i,
    output logic              busy_o,
    output logic              bit_o
);

    localparam int CNT_W = $clog2(WORD_W + 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(WORD_W);

    typedef struct packed {
        logic [WORD_W-1:0] sreg;
        logic [CNT_W-1:0]  left;
    } shift_state_t;

    shift_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.sreg = word_i;
            st_d.left = FULL_CNT;
        end else if (shift_i && (st_q.left != '0)) begin
            st_d.sreg = st_q.sreg << 1;
            st_d.left = st_q.left - 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o = (st_q.left != '0);
    assign bit_o  = st_q.sreg[WORD_W-1];

    // R7: remaining count never exceeds the word length
    assert_count_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.left <= FULL_CNT);
    // R7: once idle the serial line is low
    assert_idle_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o |-> !bit_o);
    // R6: while busy and not shifting, the count is not reloaded
    assert_hold_busy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && !shift_i) |=> st_q.left == $past(st_q.left));
    // R5: each shift while busy consumes exactly one bit
    assert_one_bit_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && shift_i && !load_i) |=> st_q.left == $past(st_q.left) - 1'b1);

endmodule

// File: rtl/sweep_irq_capture.sv
module sweep_irq_capture
    import sweep_irq_pkg::*;
#(
    parameter int INT_W       = DEF_INT_W,
    parameter int FRAC_W      = DEF_FRAC_W,
    parameter int SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              trig_i,
    input  logic [1:0]        irq_mode_i,
    input  logic [INT_W-1:0]  int_word_i,
    input  logic [FRAC_W-1:0] frac_word_i,
    input  logic              rb_clk_i,
    output logic              sweep_halt_o,
    output logic              irq_pending_o,
    output logic              rb_data_o
);

    localparam int WORD_W = INT_W + FRAC_W;

    logic trig_rise, trig_fall;
    logic rbc_rise, rbc_fall;
    logic load, busy;

    irq_sync_edge #(.STAGES(SYNC_STAGES)) trig_sync_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (trig_i),
        .rise_o  (trig_rise),
        .fall_o  (trig_fall)
    );

    irq_sync_edge #(.STAGES(SYNC_STAGES)) rbc_sync_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (rb_clk_i),
        .rise_o  (rbc_rise),
        .fall_o  (rbc_fall)
    );

    irq_capture_ctrl ctrl_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .trig_rise_i (trig_rise),
        .mode_i      (irq_mode_i),
        .busy_i      (busy),
        .load_o      (load),
        .halt_o      (sweep_halt_o)
    );

    irq_readback_shifter #(.WORD_W(WORD_W)) shift_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .load_i  (load),
        .word_i  ({int_word_i, frac_word_i}),
        .shift_i (rbc_fall),
        .busy_o  (busy),
        .bit_o   (rb_data_o)
    );

    assign irq_pending_o = busy;

    // R1: a capture follows a trigger rising edge, never a falling one
    assert_capture_on_rise_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(irq_pending_o) |-> $past(trig_rise) && !$past(trig_fall));
    // R2: capture only in a capturing mode
    assert_capture_mode_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(irq_pending_o) |-> ($past(irq_mode_i) == IRQ_RUN || $past(irq_mode_i) == IRQ_HALT));
    // R3: a capture in the run mode leaves the sweep going
    assert_run_no_halt_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($rose(irq_pending_o) && $past(irq_mode_i) == IRQ_RUN) |-> !sweep_halt_o);
    // R10: a readback clock rising edge alone moves nothing
    assert_rbc_rise_inert_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rbc_rise && !load && irq_pending_o) |=> irq_pending_o);

endmodule

// File: tb/sweep_irq_capture_tb_top.sv
module sweep_irq_capture_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trig = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic [11:0] iw = '0;
    logic [24:0] fw = '0;
    logic        rbc = 1'b0;
    logic        halt, pend, sdat;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [36:0] exp_q[$];

    always #10 clk = ~clk;

    sweep_irq_capture dut_i (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .trig_i        (trig),
        .irq_mode_i    (mode),
        .int_word_i    (iw),
        .frac_word_i   (fw),
        .rb_clk_i      (rbc),
        .sweep_halt_o  (halt),
        .irq_pending_o (pend),
        .rb_data_o     (sdat)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // driver: pulse the trigger, pushing the word when a capture is expected
    task automatic fire(input bit expect_cap);
        if (expect_cap) exp_q.push_back({iw, fw});
        trig = 1'b1;
        wait_n(6);
        trig = 1'b0;
        wait_n(6);
    endtask

    task automatic rb_pulse(output logic seen);
        rbc = 1'b1;
        wait_n(5);
        seen = sdat;
        rbc = 1'b0;
        wait_n(5);
    endtask

    // monitor: clock out a word and compare with the scoreboard head
    task automatic drain(input string req);
        logic [36:0] got;
        logic [36:0] want;
        logic b;
        want = exp_q.pop_front();
        for (int i = 36; i >= 0; i--) begin
            rb_pulse(b);
            got[i] = b;
        end
        chk(got == want, req, "readback word", got, want);
        chk(pend == 1'b0, "R7", "pending after 37 bits", pend, 0);
        chk(sdat == 1'b0, "R7", "data after 37 bits", sdat, 0);
    endtask

    initial begin
        wait_n(5);
        chk(halt == 0 && pend == 0 && sdat == 0, "R9", "outputs in reset",
            {halt, pend, sdat}, 0);
        rst_n = 1'b1;
        wait_n(3);
        chk(halt == 0 && pend == 0 && sdat == 0, "R9", "outputs after reset",
            {halt, pend, sdat}, 0);

        // R2: disabled modes
        iw = 12'h5A5; fw = 25'h1555555;
        mode = 2'b00; fire(1'b0);
        chk(pend == 0 && sdat == 0, "R2", "mode 00 capture", {pend, sdat}, 0);
        mode = 2'b10; fire(1'b0);
        chk(pend == 0 && sdat == 0 && halt == 0, "R2", "mode 10 capture", {halt, pend, sdat}, 0);

        // R10: readback clock while idle
        begin
            logic b;
            for (int k = 0; k < 3; k++) begin
                rb_pulse(b);
                chk(b == 0 && sdat == 0, "R10", "idle readback clock", b, 0);
            end
        end

        // R3 / R5: capture with sweep running
        mode = 2'b01; wait_n(3);
        iw = 12'hABC; fw = 25'h0ABCDE5;
        fire(1'b1);
        chk(pend == 1, "R3", "pending after capture", pend, 1);
        chk(halt == 0, "R3", "no halt in mode 01", halt, 0);
        chk(sdat == 1, "R5", "first bit is INT msb", sdat, 1);
        iw = 12'h000; fw = 25'h0;
        drain("R5");

        // R1: level already high gives no capture; falling edge gives none
        mode = 2'b00; wait_n(2);
        trig = 1'b1; wait_n(6);
        mode = 2'b01; wait_n(6);
        chk(pend == 0, "R1", "held-high level", pend, 0);
        trig = 1'b0; wait_n(6);
        chk(pend == 0, "R1", "falling edge", pend, 0);

        // R6: retrigger while pending keeps first word
        iw = 12'hFFF; fw = 25'h1FFFFFF;
        fire(1'b1);
        iw = 12'h123; fw = 25'h0000001;
        fire(1'b0);
        chk(pend == 1, "R6", "still pending after retrigger", pend, 1);
        drain("R6");

        // R4 / R8: halting mode
        mode = 2'b11; wait_n(3);
        chk(halt == 0, "R8", "mode change alone no halt", halt, 0);
        iw = 12'h555; fw = 25'h0AAAAAA;
        fire(1'b1);
        chk(halt == 1 && pend == 1, "R4", "halt and pending", {halt, pend}, 2'b11);
        drain("R5");
        chk(halt == 1, "R8", "halt held after readback", halt, 1);
        mode = 2'b01; wait_n(3);
        chk(halt == 0, "R8", "halt cleared by mode change", halt, 0);

        // R8 / R9: reset clears a held halt
        mode = 2'b11; wait_n(3);
        iw = 12'h801; fw = 25'h1000001;
        fire(1'b1);
        chk(halt == 1, "R4", "halt set again", halt, 1);
        void'(exp_q.pop_front());
        rst_n = 1'b0; wait_n(2);
        chk(halt == 0 && pend == 0 && sdat == 0, "R9", "reset clears all",
            {halt, pend, sdat}, 0);
        mode = 2'b00; wait_n(2);
        rst_n = 1'b1; wait_n(3);

        // R10: after idle clocks a capture still reads in full
        mode = 2'b01; wait_n(3);
        iw = 12'h3C9; fw = 25'h12F0E1D;
        fire(1'b1);
        drain("R10");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule